// File: doc/BRIEF.md
# Dual-Clock FIFO with Quadrant Direction Flags

This block moves data words from a write clock domain into a read clock domain that runs on its own unrelated clock. The words are held in an inferred RAM. Each side keeps its own pointer as a Gray code, and the RAM is addressed with those Gray values directly. Only these Gray pointers cross between the domains, each through a pair of flops clocked by the receiving side.

The full and empty flags do not use an extra wrap bit on the pointers. Each side instead keeps a single direction bit. The bit is set to "filling" when the write pointer is one quadrant behind the read pointer. It is cleared to "draining" when the write pointer is one quadrant ahead. Both tests look only at the two top Gray bits. A flag is raised when the local and synchronized pointers are equal and the direction bit points its way.

The direction bit is built from combinational next-state logic and an ordinary clocked register, so the block has no latch. No flop in the block uses an asynchronous set or reset. The `clr` input is sampled on both clocks. It must be held high for at least three edges of each clock.

Top module: `dcfifo_quad`

## Requirements
- R1: While `clr` is high, both pointers and the direction bits return to zero. On the first edge after `clr` falls, `empty` is 1 and `full` is 0.
- R2: Words leave the read port in the same order they were accepted at the write port, with no loss and no duplication.
- R3: A write attempted while `full` is 1 is ignored: the write pointer does not move and no stored word is changed.
- R4: A read attempted while `empty` is 1 is ignored: the read pointer does not move and `rd_data` keeps its value.
- R5: Each pointer changes by at most one bit per clock of its own domain (Gray stepping).
- R6: With no reads, exactly 2^ADDR_W writes (16 by default) are accepted before `full` goes to 1.
- R7: After a write into an empty FIFO, `empty` is 0 no later than the third read clock edge after the write edge.
- R8: `rd_data` holds the word read, starting from the read clock edge that accepts the read.
- R9: After a read from a full FIFO, `full` is 0 no later than the third write clock edge after the read edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clr | input | 1 | Synchronous clear, sampled by both clocks, active high |
| wr_clk | input | 1 | Write domain clock |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No space left; writes are ignored |
| rd_clk | input | 1 | Read domain clock |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Word returned by the last accepted read |
| empty | output | 1 | Nothing stored; reads are ignored |

## Verification
The hardest cases to reach are the edges of the direction bit. One is the moment the writer catches the reader from behind, which must raise `full` and not `empty`. The other is the instant the flag drops after the far pointer crosses the synchronizers. The bench reaches these with long one-sided runs that fill the FIFO completely and then empty it completely, and with single-word transfers timed from the accepting edge. Random phases then drive the pointers through many wraps at several write and read rates, and every word is compared against a behavioural queue.

// File: rtl/dcfifo_quad.sv
module dcfifo_quad #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clr,
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  input  logic              rd_clk,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI = ADDR_W - 1;
  localparam int LO = ADDR_W - 2;

  logic [DATA_W-1:0] mem [DEPTH];

  // write domain
  logic [ADDR_W-1:0] wbin, wgray, rq1, rq2, wbin_nxt;
  logic wdir, wdir_q, w_set, w_rst, wr_go;

  assign wbin_nxt = wbin + 1'b1;
  assign wr_go    = wr_en & ~full;

  always_ff @(posedge wr_clk) begin
    if (clr) begin
      wbin  <= '0;
      wgray <= '0;
      rq1   <= '0;
      rq2   <= '0;
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
      if (wr_go) begin
        wbin  <= wbin_nxt;
        wgray <= wbin_nxt ^ (wbin_nxt >> 1);
      end
    end
  end

  always_ff @(posedge wr_clk)
    if (wr_go) mem[wgray] <= wr_data;

  assign w_set = (wgray[LO] ~^ rq2[HI]) & (wgray[HI] ^ rq2[LO]);
  assign w_rst = (wgray[LO] ^ rq2[HI]) & (wgray[HI] ~^ rq2[LO]);

  always_comb begin
    if (clr | w_rst)  wdir = 1'b0;
    else if (w_set)   wdir = 1'b1;
    else              wdir = wdir_q;
  end

  always_ff @(posedge wr_clk) wdir_q <= wdir;

  assign full = wdir & (wgray == rq2);

  // read domain
  logic [ADDR_W-1:0] rbin, rgray, wq1, wq2, rbin_nxt;
  logic rdir, rdir_q, r_set, r_rst, rd_go;

  assign rbin_nxt = rbin + 1'b1;
  assign rd_go    = rd_en & ~empty;

  always_ff @(posedge rd_clk) begin
    if (clr) begin
      rbin  <= '0;
      rgray <= '0;
      wq1   <= '0;
      wq2   <= '0;
    end else begin
      wq1 <= wgray;
      wq2 <= wq1;
      if (rd_go) begin
        rbin  <= rbin_nxt;
        rgray <= rbin_nxt ^ (rbin_nxt >> 1);
      end
    end
  end

  always_ff @(posedge rd_clk)
    if (rd_go) rd_data <= mem[rgray];

  assign r_set = (wq2[LO] ~^ rgray[HI]) & (wq2[HI] ^ rgray[LO]);
  assign r_rst = (wq2[LO] ^ rgray[HI]) & (wq2[HI] ~^ rgray[LO]);

  always_comb begin
    if (clr | r_rst)  rdir = 1'b0;
    else if (r_set)   rdir = 1'b1;
    else              rdir = rdir_q;
  end

  always_ff @(posedge rd_clk) rdir_q <= rdir;

  assign empty = ~rdir & (wq2 == rgray);

  // R1
  clear_empty_chk: assert property (@(posedge rd_clk) disable iff (clr)
    $past(clr) |-> empty);
  // R1
  clear_full_chk: assert property (@(posedge wr_clk) disable iff (clr)
    $past(clr) |-> !full);
  // R3
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (clr)
    (wr_en && full) |=> $stable(wgray));
  // R4
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (clr)
    (rd_en && empty) |=> $stable(rgray));
  // R5
  wr_gray_step_chk: assert property (@(posedge wr_clk) disable iff (clr)
    $countones(wgray ^ $past(wgray)) <= 1);
  // R5
  rd_gray_step_chk: assert property (@(posedge rd_clk) disable iff (clr)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: tb/dcfifo_quad_tb.sv
`timescale 1ns/1ps
module dcfifo_quad_tb;
  localparam int DW = 8;
  localparam int DEPTH = 16;

  logic clr = 1'b1;
  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic full, empty;

  dcfifo_quad #(.DATA_W(DW), .ADDR_W(4)) u_dut (
    .clr(clr), .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(rd_data), .empty(empty));

  always #2.5 wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  int checks = 0, errors = 0;
  int wr_prob = 0, rd_prob = 0;
  int wr_acc = 0, rd_acc = 0;
  bit wr_one = 0, rd_one = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] last_push;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // write side model
  initial begin
    forever begin
      @(negedge wr_clk);
      if (clr) begin
        wr_en = 1'b0;
      end else begin
        bit go;
        logic [DW-1:0] d;
        go = wr_one || ($urandom_range(99) < wr_prob);
        wr_one = 0;
        d = DW'($urandom);
        wr_en = go;
        wr_data = d;
        if (go && !full) begin
          // R3: model occupancy never exceeds depth
          chk(q.size() < DEPTH, "R3 accepted write beyond depth", q.size(), DEPTH - 1);
          q.push_back(d);
          last_push = d;
          wr_acc++;
        end
      end
    end
  end

  // read side model
  initial begin
    bit pend = 0, hold = 0;
    logic [DW-1:0] exp_d, held;
    forever begin
      @(negedge rd_clk);
      if (pend) chk(rd_data === exp_d, "R2 read data order", int'(rd_data), int'(exp_d));
      if (hold) chk(rd_data === held, "R4 data held on ignored read", int'(rd_data), int'(held));
      pend = 0;
      hold = 0;
      if (clr) begin
        rd_en = 1'b0;
      end else begin
        bit go;
        go = rd_one || ($urandom_range(99) < rd_prob);
        rd_one = 0;
        rd_en = go;
        if (go && !empty) begin
          chk(q.size() > 0, "R4 read accepted with model empty", q.size(), 1);
          if (q.size() > 0) begin
            exp_d = q.pop_front();
            pend = 1;
            rd_acc++;
          end
        end else if (go && empty) begin
          held = rd_data;
          hold = 1;
        end
      end
    end
  end

  task automatic do_clear();
    wr_prob = 0;
    rd_prob = 0;
    repeat (4) @(negedge rd_clk);
    clr = 1'b1;
    repeat (4) @(posedge rd_clk);
    repeat (4) @(posedge wr_clk);
    q.delete();
    @(negedge wr_clk);
    clr = 1'b0;
    repeat (2) @(posedge rd_clk);
    #1;
    chk(empty == 1'b1, "R1 empty after clear", empty, 1);
    chk(full == 1'b0, "R1 full after clear", full, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int wa0, ra0;
    repeat (5) @(posedge wr_clk);
    repeat (5) @(posedge rd_clk);
    #1;
    chk(empty == 1'b1, "R1 empty in clear", empty, 1);
    chk(full == 1'b0, "R1 full in clear", full, 0);
    do_clear();

    // R6 / R3: fill with no reads, extra writes ignored
    wa0 = wr_acc;
    wr_prob = 100;
    repeat (30) @(negedge wr_clk);
    wr_prob = 0;
    repeat (2) @(negedge wr_clk);
    chk(wr_acc - wa0 == DEPTH, "R6 writes accepted until full", wr_acc - wa0, DEPTH);
    chk(full == 1'b1, "R6 full after depth writes", full, 1);
    chk(empty == 1'b0, "R6 not empty when full", empty, 0);

    // R2 / R4: drain, then extra reads ignored
    ra0 = rd_acc;
    rd_prob = 100;
    repeat (30) @(negedge rd_clk);
    rd_prob = 0;
    repeat (3) @(negedge rd_clk);
    chk(rd_acc - ra0 == DEPTH, "R2 reads returned all words", rd_acc - ra0, DEPTH);
    chk(empty == 1'b1, "R4 empty after drain", empty, 1);
    chk(q.size() == 0, "R2 model drained", q.size(), 0);

    // R7: single write into empty FIFO
    wr_one = 1;
    wait (wr_one == 0);
    @(posedge wr_clk);
    repeat (3) @(posedge rd_clk);
    #1;
    chk(empty == 1'b0, "R7 empty released", empty, 0);

    // R8: data present at accepting edge
    rd_one = 1;
    wait (rd_one == 0);
    @(posedge rd_clk);
    #1;
    chk(rd_data === last_push, "R8 data at accepting edge", int'(rd_data), int'(last_push));
    repeat (3) @(negedge rd_clk);
    chk(empty == 1'b1, "R4 empty after single read", empty, 1);

    // R9: one read from full
    wr_prob = 100;
    repeat (30) @(negedge wr_clk);
    wr_prob = 0;
    repeat (2) @(negedge wr_clk);
    chk(full == 1'b1, "R9 full before read", full, 1);
    rd_one = 1;
    wait (rd_one == 0);
    @(posedge rd_clk);
    repeat (3) @(posedge wr_clk);
    #1;
    chk(full == 1'b0, "R9 full released", full, 0);

    // R2 / R5: random traffic across many pointer wraps
    wr_prob = 70; rd_prob = 30; repeat (3000) @(negedge wr_clk);
    wr_prob = 30; rd_prob = 70; repeat (3000) @(negedge wr_clk);
    wr_prob = 50; rd_prob = 50; repeat (3000) @(negedge wr_clk);
    wr_prob = 90; rd_prob = 90; repeat (3000) @(negedge wr_clk);
    wr_prob = 0;  rd_prob = 100; repeat (60) @(negedge rd_clk);
    rd_prob = 0;
    repeat (3) @(negedge rd_clk);
    chk(empty == 1'b1, "R5 empty after wraps", empty, 1);
    chk(q.size() == 0, "R2 model empty after wraps", q.size(), 0);

    // R1: clear with data inside
    wr_prob = 100;
    repeat (8) @(negedge wr_clk);
    do_clear();
    wr_prob = 100; rd_prob = 100;
    repeat (200) @(negedge wr_clk);
    wr_prob = 0;
    repeat (60) @(negedge rd_clk);
    rd_prob = 0;
    repeat (3) @(negedge rd_clk);
    chk(q.size() == 0, "R1 clean restart after clear", q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule